// File: doc/BRIEF.md
# Detection Box Pre-Filter Engine

This block screens candidate detection boxes before any overlap (IoU) work is done. Boxes arrive one per cycle. Each box carries a class number, a confidence value and the four corners of its rectangle. There are two modes. In inference mode a box survives only when its confidence reaches a programmable threshold. In training mode a box survives only when its center point lies inside at least one loaded ground-truth rectangle.

Each surviving box is appended to the buffer that belongs to its class. At the same time the block keeps, per class, the survivor with the highest confidence. In a suppression flow that box serves as the first reference box. Later stages therefore receive small, independent per-class lists that they can process in parallel.

A frame ends with an end-of-frame strobe. One cycle later the block pulses `done`. From then on the counts, the maxima, the overflow flags and the lists are stable and can be read. They stay that way until the first box of the next frame arrives.

Top module: `box_prefilter`

## Requirements
- R1: In inference mode (`mode_train`=0), a box is kept when `in_conf >= conf_thresh` and dropped otherwise; a confidence equal to the threshold is kept. The ground-truth contents have no effect in this mode.
- R2: In training mode (`mode_train`=1), the center is cx=(x1+x2)>>1 and cy=(y1+y2)>>1, computed on a 17-bit sum. A box is kept when some enabled ground-truth slot satisfies gx1<=cx<=gx2 and gy1<=cy<=gy2, with all bounds inclusive. Confidence has no effect in this mode.
- R3: A write with `gt_wr_en`=1 loads the slot `gt_wr_slot` with the given corners and with enable bit `gt_wr_vld`. A slot whose enable bit is 0 never causes a box to be kept. All slots are tested against every box.
- R4: A kept box of class c is stored in entry `count[c]` of list c. The stored value is the box's frame index: the number of boxes, kept or dropped, that were presented in this frame before it (the first box has index 0). Setting `rd_class` and `rd_addr` returns that entry on `rd_box_idx` in the same cycle.
- R5: `cls_count` holds, for class c, the number of kept boxes stored in this frame. Field c occupies bits [c*CNT_W +: CNT_W], with CNT_W=7 by default.
- R6: For each class with a nonzero count, `cls_max_conf` and `cls_max_idx` give the confidence and frame index of the stored box with the highest confidence. When confidences are equal, the earlier box is the one reported. `cls_max_vld[c]` is 1 exactly when the count of class c is nonzero.
- R7: A kept box that arrives when its class list already holds DEPTH (64) entries is discarded. It changes neither the count nor the maximum, and it sets `cls_overflow[c]`. That flag stays set for the rest of the frame.
- R8: `done` is high for exactly one cycle, the cycle after `in_eof` is sampled. A box presented together with `in_eof` belongs to the ending frame. All results hold until the first box of the next frame, which clears the counts and overflow flags and restarts the frame index at 0.
- R9: After reset, all counts are 0, all overflow flags and `cls_max_vld` are 0, and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_train | input | 1 | 1 selects center gating, 0 selects threshold gating |
| conf_thresh | input | 8 | Confidence threshold used in inference mode |
| gt_wr_en | input | 1 | Ground-truth slot write strobe |
| gt_wr_slot | input | 3 | Ground-truth slot being written |
| gt_wr_vld | input | 1 | Enable bit stored with the slot |
| gt_wr_x1 | input | 16 | Ground-truth left edge |
| gt_wr_y1 | input | 16 | Ground-truth top edge |
| gt_wr_x2 | input | 16 | Ground-truth right edge |
| gt_wr_y2 | input | 16 | Ground-truth bottom edge |
| in_valid | input | 1 | Candidate box present |
| in_eof | input | 1 | End of frame strobe |
| in_class | input | 2 | Class of the box |
| in_conf | input | 8 | Confidence of the box |
| in_x1 | input | 16 | Box left corner |
| in_y1 | input | 16 | Box top corner |
| in_x2 | input | 16 | Box right corner |
| in_y2 | input | 16 | Box bottom corner |
| done | output | 1 | One-cycle frame completion pulse |
| cls_count | output | 28 | Per-class kept counts, 7 bits per class |
| cls_max_vld | output | 4 | Per-class maximum present |
| cls_max_conf | output | 32 | Per-class maximum confidence, 8 bits per class |
| cls_max_idx | output | 64 | Per-class frame index of the maximum, 16 bits per class |
| cls_overflow | output | 4 | Per-class sticky list overflow |
| rd_class | input | 2 | Class list to read |
| rd_addr | input | 6 | Entry within the list |
| rd_box_idx | output | 16 | Stored frame index at that entry |

## Verification
A wrong gate decision shows up at the `done` pulse of the same frame: the class count is off by one, and from that entry onward the list read-back is shifted. A corrupted tracker shows up as a wrong maximum index at the same point. The test for equal confidences catches a tracker that prefers the later box. If the frame restart is missed, the next frame's counts start from stale values. A missing overflow guard shows up as a count above 64 or as a maximum taken from a discarded box, both visible in the frame that filled the list.

// File: rtl/pf_pkg.sv
package pf_pkg;
   localparam int PF_CW = 16;

   typedef struct packed {
      logic             en;
      logic [PF_CW-1:0] x1;
      logic [PF_CW-1:0] y1;
      logic [PF_CW-1:0] x2;
      logic [PF_CW-1:0] y2;
   } gt_rect_t;
endpackage

// File: rtl/pf_gate.sv
module pf_gate
   import pf_pkg::*;
#(
   parameter int NUM_GT  = 8,
   parameter int CONF_W  = 8,
   localparam int SLOT_W = (NUM_GT > 1) ? $clog2(NUM_GT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_train,
   input  logic [CONF_W-1:0] conf_thresh,
   input  logic              gt_wr_en,
   input  logic [SLOT_W-1:0] gt_wr_slot,
   input  gt_rect_t          gt_wr_rect,
   input  logic [CONF_W-1:0] conf,
   input  logic [PF_CW-1:0]  x1,
   input  logic [PF_CW-1:0]  y1,
   input  logic [PF_CW-1:0]  x2,
   input  logic [PF_CW-1:0]  y2,
   output logic              keep
);
   gt_rect_t         slots [NUM_GT];
   logic [NUM_GT-1:0] hit;
   logic [PF_CW:0]   sum_x, sum_y;
   logic [PF_CW-1:0] cx, cy;

   assign sum_x = {1'b0, x1} + {1'b0, x2};
   assign sum_y = {1'b0, y1} + {1'b0, y2};
   assign cx    = sum_x[PF_CW:1];
   assign cy    = sum_y[PF_CW:1];

   for (genvar g = 0; g < NUM_GT; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slots[g] <= '0;
         else if (gt_wr_en && gt_wr_slot == SLOT_W'(g))
            slots[g] <= gt_wr_rect;
      end
      assign hit[g] = slots[g].en &&
                      (cx >= slots[g].x1) && (cx <= slots[g].x2) &&
                      (cy >= slots[g].y1) && (cy <= slots[g].y2);
   end

   assign keep = mode_train ? (|hit) : (conf >= conf_thresh);
endmodule

// File: rtl/pf_bin.sv
module pf_bin #(
   parameter int DEPTH  = 64,
   parameter int IDX_W  = 16,
   parameter int CONF_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr,
   input  logic [CONF_W-1:0] conf,
   input  logic [IDX_W-1:0]  idx,
   input  logic [AW-1:0]     rd_addr,
   output logic [CNT_W-1:0]  cnt,
   output logic [CONF_W-1:0] max_conf,
   output logic [IDX_W-1:0]  max_idx,
   output logic              ovf,
   output logic [IDX_W-1:0]  rd_data
);
   logic [IDX_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0] cnt_base;
   logic             full, store;

   assign cnt_base = start ? '0 : cnt;
   assign full     = (cnt_base == CNT_W'(DEPTH));
   assign store    = wr && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         ovf      <= 1'b0;
         max_conf <= '0;
         max_idx  <= '0;
      end else begin
         if (start) begin
            cnt <= '0;
            ovf <= 1'b0;
         end
         if (wr && full)
            ovf <= 1'b1;
         if (store) begin
            cnt <= cnt_base + CNT_W'(1);
            if (cnt_base == '0 || conf > max_conf) begin
               max_conf <= conf;
               max_idx  <= idx;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (store)
         mem[cnt_base[AW-1:0]] <= idx;
   end

   assign rd_data = mem[rd_addr];

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));
   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !start) |=> ovf);
   // R6
   max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !start) |=> (max_conf >= $past(max_conf)));
endmodule

// File: rtl/box_prefilter.sv
module box_prefilter
   import pf_pkg::*;
#(
   parameter int NUM_CLASSES = 4,
   parameter int DEPTH       = 64,
   parameter int NUM_GT      = 8,
   parameter int COORD_W     = 16,
   parameter int CONF_W      = 8,
   parameter int IDX_W       = 16,
   localparam int CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int SLOT_W = (NUM_GT > 1) ? $clog2(NUM_GT) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         mode_train,
   input  logic [CONF_W-1:0]            conf_thresh,
   input  logic                         gt_wr_en,
   input  logic [SLOT_W-1:0]            gt_wr_slot,
   input  logic                         gt_wr_vld,
   input  logic [COORD_W-1:0]           gt_wr_x1,
   input  logic [COORD_W-1:0]           gt_wr_y1,
   input  logic [COORD_W-1:0]           gt_wr_x2,
   input  logic [COORD_W-1:0]           gt_wr_y2,
   input  logic                         in_valid,
   input  logic                         in_eof,
   input  logic [CLS_W-1:0]             in_class,
   input  logic [CONF_W-1:0]            in_conf,
   input  logic [COORD_W-1:0]           in_x1,
   input  logic [COORD_W-1:0]           in_y1,
   input  logic [COORD_W-1:0]           in_x2,
   input  logic [COORD_W-1:0]           in_y2,
   output logic                         done,
   output logic [NUM_CLASSES*CNT_W-1:0] cls_count,
   output logic [NUM_CLASSES-1:0]       cls_max_vld,
   output logic [NUM_CLASSES*CONF_W-1:0] cls_max_conf,
   output logic [NUM_CLASSES*IDX_W-1:0] cls_max_idx,
   output logic [NUM_CLASSES-1:0]       cls_overflow,
   input  logic [CLS_W-1:0]             rd_class,
   input  logic [AW-1:0]                rd_addr,
   output logic [IDX_W-1:0]             rd_box_idx
);
   if (COORD_W != PF_CW) begin : g_bad_cw
      $error("COORD_W must equal the package coordinate width");
   end
   if (NUM_CLASSES != (1 << CLS_W)) begin : g_bad_cls
      $error("NUM_CLASSES must be a power of two");
   end
   if (DEPTH < 2 || NUM_GT < 1) begin : g_bad_dim
      $error("DEPTH must be at least 2 and NUM_GT at least 1");
   end

   logic             fresh, start, keep;
   logic [IDX_W-1:0] idx_cnt, idx_base;
   logic [IDX_W-1:0] bin_rd [NUM_CLASSES];
   gt_rect_t         wr_rect;

   assign wr_rect  = '{en: gt_wr_vld, x1: gt_wr_x1, y1: gt_wr_y1,
                       x2: gt_wr_x2, y2: gt_wr_y2};
   assign start    = in_valid && fresh;
   assign idx_base = start ? '0 : idx_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh   <= 1'b1;
         idx_cnt <= '0;
         done    <= 1'b0;
      end else begin
         done <= in_eof;
         if (in_eof)
            fresh <= 1'b1;
         else if (in_valid)
            fresh <= 1'b0;
         if (in_valid)
            idx_cnt <= idx_base + IDX_W'(1);
      end
   end

   pf_gate #(.NUM_GT(NUM_GT), .CONF_W(CONF_W)) gate_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_train (mode_train),
      .conf_thresh(conf_thresh),
      .gt_wr_en   (gt_wr_en),
      .gt_wr_slot (gt_wr_slot),
      .gt_wr_rect (wr_rect),
      .conf       (in_conf),
      .x1         (in_x1),
      .y1         (in_y1),
      .x2         (in_x2),
      .y2         (in_y2),
      .keep       (keep)
   );

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_bin
      logic [CNT_W-1:0] cnt_c;
      pf_bin #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CONF_W(CONF_W)) bin_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .start   (start),
         .wr      (in_valid && keep && in_class == CLS_W'(c)),
         .conf    (in_conf),
         .idx     (idx_base),
         .rd_addr (rd_addr),
         .cnt     (cnt_c),
         .max_conf(cls_max_conf[c*CONF_W +: CONF_W]),
         .max_idx (cls_max_idx[c*IDX_W +: IDX_W]),
         .ovf     (cls_overflow[c]),
         .rd_data (bin_rd[c])
      );
      assign cls_count[c*CNT_W +: CNT_W] = cnt_c;
      assign cls_max_vld[c] = (cnt_c != '0);
   end

   assign rd_box_idx = bin_rd[rd_class];

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !in_eof) |=> !done);
endmodule

// File: tb/box_prefilter_tb_top.sv
`timescale 1ns/1ps
module box_prefilter_tb_top;
   localparam int NC = 4, DEPTH = 64, CW = 7;

   typedef struct packed {
      logic [6:0]  cnt;
      logic [7:0]  mconf;
      logic [15:0] midx;
      logic        ovf;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic mode_train = 0;
   logic [7:0] conf_thresh = 0;
   logic gt_wr_en = 0, gt_wr_vld = 0;
   logic [2:0] gt_wr_slot = 0;
   logic [15:0] gt_wr_x1 = 0, gt_wr_y1 = 0, gt_wr_x2 = 0, gt_wr_y2 = 0;
   logic in_valid = 0, in_eof = 0;
   logic [1:0] in_class = 0;
   logic [7:0] in_conf = 0;
   logic [15:0] in_x1 = 0, in_y1 = 0, in_x2 = 0, in_y2 = 0;
   logic done;
   logic [NC*CW-1:0] cls_count;
   logic [NC-1:0] cls_max_vld, cls_overflow;
   logic [NC*8-1:0] cls_max_conf;
   logic [NC*16-1:0] cls_max_idx;
   logic [1:0] rd_class = 0;
   logic [5:0] rd_addr = 0;
   logic [15:0] rd_box_idx;

   int checks = 0, errors = 0, frames_seen = 0;

   // model state
   int m_cnt [NC], m_mc [NC], m_mi [NC], m_list [NC][DEPTH];
   bit m_ovf [NC];
   int m_idx = 0;
   bit m_fresh = 1;
   bit g_en [8];
   int g_x1 [8], g_y1 [8], g_x2 [8], g_y2 [8];
   exp_t exp_q [$];

   always #5 clk = ~clk;

   box_prefilter dut_i (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic write_gt(input int slot, input bit en, input int x1, y1, x2, y2);
      @(negedge clk);
      gt_wr_en = 1; gt_wr_slot = 3'(slot); gt_wr_vld = en;
      gt_wr_x1 = 16'(x1); gt_wr_y1 = 16'(y1); gt_wr_x2 = 16'(x2); gt_wr_y2 = 16'(y2);
      g_en[slot] = en; g_x1[slot] = x1; g_y1[slot] = y1; g_x2[slot] = x2; g_y2[slot] = y2;
      @(negedge clk);
      gt_wr_en = 0;
   endtask

   // driver: drives one box and updates the model (R1, R2, R3, R4)
   task automatic send_box(input int cls, conf, x1, y1, x2, y2, input bit eof);
      bit keep;
      int cx, cy;
      @(negedge clk);
      in_valid = 1; in_eof = eof; in_class = 2'(cls); in_conf = 8'(conf);
      in_x1 = 16'(x1); in_y1 = 16'(y1); in_x2 = 16'(x2); in_y2 = 16'(y2);
      if (m_fresh) begin
         for (int c = 0; c < NC; c++) begin m_cnt[c] = 0; m_ovf[c] = 0; end
         m_idx = 0; m_fresh = 0;
      end
      cx = (x1 + x2) >> 1; cy = (y1 + y2) >> 1;
      keep = 0;
      if (mode_train) begin
         for (int g = 0; g < 8; g++)
            if (g_en[g] && cx >= g_x1[g] && cx <= g_x2[g] && cy >= g_y1[g] && cy <= g_y2[g])
               keep = 1;
      end else keep = (conf >= int'(conf_thresh));
      if (keep) begin
         if (m_cnt[cls] == DEPTH) m_ovf[cls] = 1;
         else begin
            if (m_cnt[cls] == 0 || conf > m_mc[cls]) begin m_mc[cls] = conf; m_mi[cls] = m_idx; end
            m_list[cls][m_cnt[cls]] = m_idx;
            m_cnt[cls]++;
         end
      end
      m_idx++;
      if (eof) end_frame_model();
   endtask

   function automatic void end_frame_model();
      for (int c = 0; c < NC; c++)
         exp_q.push_back('{cnt: 7'(m_cnt[c]), mconf: 8'(m_mc[c]), midx: 16'(m_mi[c]), ovf: m_ovf[c]});
      m_fresh = 1;
   endfunction

   task automatic finish_frame(input int n);
      @(negedge clk);
      in_valid = 0; in_eof = 0;
      wait (frames_seen == n);
   endtask

   // monitor: pops expected per-class results at each done pulse
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            for (int c = 0; c < NC; c++) begin
               exp_t e;
               int cnt;
               e = exp_q.pop_front();
               cnt = int'(cls_count[c*CW +: CW]);
               check(cnt == int'(e.cnt), "R5 count", cnt, int'(e.cnt));
               check(cls_overflow[c] == e.ovf, "R7 overflow", int'(cls_overflow[c]), int'(e.ovf));
               check(cls_max_vld[c] == (e.cnt != 0), "R6 max valid", int'(cls_max_vld[c]), int'(e.cnt != 0));
               if (e.cnt != 0) begin
                  check(cls_max_conf[c*8 +: 8] == e.mconf, "R6 max conf",
                        int'(cls_max_conf[c*8 +: 8]), int'(e.mconf));
                  check(cls_max_idx[c*16 +: 16] == e.midx, "R6 max index",
                        int'(cls_max_idx[c*16 +: 16]), int'(e.midx));
               end
            end
            for (int c = 0; c < NC; c++)
               for (int k = 0; k < m_cnt[c]; k++) begin
                  rd_class = 2'(c); rd_addr = 6'(k);
                  #0.1;
                  check(int'(rd_box_idx) == m_list[c][k], "R4 list entry", int'(rd_box_idx), m_list[c][k]);
               end
            @(negedge clk);
            check(done == 1'b0, "R8 done single cycle", int'(done), 0);
            frames_seen++;
         end
      end
   end

   initial begin
      #1_000_000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", frames_seen, 4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int g = 0; g < 8; g++) g_en[g] = 0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(cls_count == '0, "R9 counts", int'(cls_count), 0);
      check(cls_overflow == '0, "R9 overflow", int'(cls_overflow), 0);
      check(cls_max_vld == '0, "R9 max valid", int'(cls_max_vld), 0);
      check(done == 1'b0, "R9 done", int'(done), 0);
      rst_n = 1;

      // Frame 1, R1: threshold 100, equal kept, 99 dropped; GT slot enabled but ignored; tie in class 1
      write_gt(0, 1, 0, 0, 5, 5);
      mode_train = 0; conf_thresh = 100;
      send_box(0, 100, 1, 1, 2, 2, 0);
      send_box(0, 99, 1, 1, 2, 2, 0);
      send_box(1, 150, 50, 50, 60, 60, 0);
      send_box(1, 150, 0, 0, 4, 4, 0);
      send_box(0, 200, 9, 9, 9, 9, 0);
      send_box(2, 50, 0, 0, 1, 1, 0);
      send_box(3, 255, 7, 7, 8, 8, 0);
      send_box(1, 120, 3, 3, 3, 3, 1);
      finish_frame(1);

      // Frame 2, R2 and R3: center gating, inclusive edges, disabled slot, odd sums
      mode_train = 1; conf_thresh = 255;
      write_gt(0, 1, 10, 10, 20, 20);
      write_gt(5, 1, 100, 100, 200, 150);
      write_gt(3, 0, 300, 300, 400, 400);
      send_box(0, 0, 10, 10, 10, 10, 0);
      send_box(0, 5, 20, 20, 20, 20, 0);
      send_box(1, 9, 21, 15, 21, 15, 0);
      send_box(2, 3, 299, 350, 302, 350, 0);
      send_box(2, 7, 19, 14, 22, 14, 0);
      send_box(3, 1, 150, 140, 150, 160, 0);
      send_box(3, 2, 150, 150, 150, 152, 0);
      send_box(1, 4, 99, 120, 100, 120, 1);
      finish_frame(2);

      // Frame 3, R7: 70 kept boxes into class 2; late high confidence discarded
      mode_train = 0; conf_thresh = 0;
      for (int i = 0; i < 70; i++)
         send_box(2, (i == 66) ? 255 : (i % 50), 0, 0, 1, 1, 0);
      send_box(0, 10, 0, 0, 1, 1, 1);
      finish_frame(3);

      // Frame 4, R8: first box restarts counts, overflow and index
      conf_thresh = 30;
      send_box(2, 40, 0, 0, 1, 1, 0);
      send_box(2, 10, 0, 0, 1, 1, 0);
      send_box(2, 60, 0, 0, 1, 1, 1);
      finish_frame(4);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule